// File: doc/BRIEF.md
# Opposite-Edge Reset Release Generator

This block derives the internal resets of a single clock domain from an active-low board reset and an active-high software reset request. It drives two active-low outputs. One feeds flops that capture on the rising clock edge and leaves reset on a falling edge. The other feeds flops that capture on the falling clock edge and leaves reset on a rising edge. Because release always happens on the edge the target flops do not use, those flops get half a cycle of recovery margin.

When the board reset falls, both outputs fall at once, even if the clock is stopped. When it rises, a short chain of flops clocked on the release edge carries the rise to each output, which guards against metastability. The software request is sampled on each output's release edge, so it both asserts and releases that output on that edge alone. In scan mode the outputs follow the board reset directly and bypass all sequential logic. Release is not coordinated with other domains, so a slower domain can stay in reset after a faster one is already running.

Top module: `edge_reset_gen`

## Requirements
- R1: While `extRstN` is 0 and `scanMode` is 0, both `rstPosN` and `rstNegN` are 0. They fall as soon as `extRstN` falls, and the clock does not need to run.
- R2: After `extRstN` rises, `rstPosN` rises on the falling clock edge that is the `STAGES`-th one (default 2) after the rise, and stays 0 before that edge.
- R3: After `extRstN` rises, `rstNegN` rises on the rising clock edge that is the `STAGES`-th one (default 2) after the rise, and stays 0 before that edge.
- R4: When `swRst` is 1 at a falling edge, `rstPosN` falls on that edge. It does not fall earlier.
- R5: When `swRst` is 1 at a rising edge, `rstNegN` falls on that edge. It does not fall earlier.
- R6: After `swRst` returns to 0, each output rises on the first of its own release edges at which it samples 0.
- R7: While `scanMode` is 1, both outputs equal `extRstN` combinationally, and `swRst` has no effect on them.
- R8: With the clock running, both outputs stay at 0 for as long as `extRstN` is held at 0.
- R9: When the clock is stopped, a rise of `extRstN` does not release either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| extRstN | input | 1 | Board reset, active low, asynchronous |
| swRst | input | 1 | Software reset request, active high, level |
| scanMode | input | 1 | Scan mode: outputs follow extRstN |
| rstPosN | output | 1 | Reset for rising-edge flops, released on a falling edge |
| rstNegN | output | 1 | Reset for falling-edge flops, released on a rising edge |

## Verification
On every edge, the assertions check that both outputs are held low while the board reset is low. They check that a sampled software request has pulled the matching output low, that `rstPosN` only rises at a falling edge that follows a high board reset, and that both outputs stay high in scan mode once the board reset is high. Only the bench scenarios can show the other properties. These are that assertion happens with the clock frozen, that a rise of the board reset releases nothing while the clock is frozen, and that each output leaves reset on exactly the edge and edge count intended. The bench also shows that the scan path reacts within a fraction of a cycle, between edges.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

  // Strobes handed from the control side to the release datapath.
  typedef struct packed {
    logic chainClrN;  // asynchronous clear for the release chains
    logic holdPos;    // software hold for the rising-edge-flop output
    logic holdNeg;    // software hold for the falling-edge-flop output
    logic bypass;     // scan: outputs follow the board reset
  } rstStrobes_t;

endpackage

// File: rtl/reset_ctrl.sv
module reset_ctrl
  import rstgen_pkg::*;
(
  input  logic        clk,
  input  logic        extRstN,
  input  logic        swRst,
  input  logic        scanMode,
  output rstStrobes_t strobes
);

  // During scan the chains are kept out of reset so that they can be controlled.
  logic clrN;
  assign clrN = extRstN | scanMode;

  logic holdPosQ;
  logic holdNegQ;

  // Software request sampled on the release edge of each output.
  always_ff @(negedge clk or negedge clrN) begin
    if (!clrN) holdPosQ <= 1'b0;
    else       holdPosQ <= swRst;
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) holdNegQ <= 1'b0;
    else       holdNegQ <= swRst;
  end

  always_comb begin
    strobes.chainClrN = clrN;
    strobes.holdPos   = holdPosQ;
    strobes.holdNeg   = holdNegQ;
    strobes.bypass    = scanMode;
  end

endmodule

// File: rtl/reset_chains.sv
module reset_chains
  import rstgen_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        extRstN,
  input  rstStrobes_t strobes,
  output logic        rstPosN,
  output logic        rstNegN
);

  localparam int LAST = STAGES - 1;
  localparam int NUM_OUTS = 2;  // index 0: falling-edge release, 1: rising-edge release

  logic clrN;
  assign clrN = strobes.chainClrN;

  logic [NUM_OUTS-1:0] chainDone;

  for (genvar g = 0; g < NUM_OUTS; g++) begin : g_chain
    logic [LAST:0] stageQ;
    if (g == 0) begin : g_fall
      always_ff @(negedge clk or negedge clrN) begin
        if (!clrN) stageQ <= '0;
        else       stageQ <= {stageQ[LAST-1:0], 1'b1};
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge clrN) begin
        if (!clrN) stageQ <= '0;
        else       stageQ <= {stageQ[LAST-1:0], 1'b1};
      end
    end
    assign chainDone[g] = stageQ[LAST];
  end

  always_comb begin
    if (strobes.bypass) begin
      rstPosN = extRstN;
      rstNegN = extRstN;
    end else begin
      rstPosN = chainDone[0] & ~strobes.holdPos;
      rstNegN = chainDone[1] & ~strobes.holdNeg;
    end
  end

endmodule

// File: rtl/edge_reset_gen.sv
module edge_reset_gen
  import rstgen_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic extRstN,
  input  logic swRst,
  input  logic scanMode,
  output logic rstPosN,
  output logic rstNegN
);

  rstStrobes_t strobes;

  reset_ctrl u_ctrl (
    .clk      (clk),
    .extRstN  (extRstN),
    .swRst    (swRst),
    .scanMode (scanMode),
    .strobes  (strobes)
  );

  reset_chains #(.STAGES(STAGES)) u_chains (
    .clk      (clk),
    .extRstN  (extRstN),
    .strobes  (strobes),
    .rstPosN  (rstPosN),
    .rstNegN  (rstNegN)
  );

endmodule

// File: rtl/edge_reset_gen_chk.sv
module edge_reset_gen_chk (
  input logic clk,
  input logic extRstN,
  input logic swRst,
  input logic scanMode,
  input logic rstPosN,
  input logic rstNegN
);

  // R1 / R8: a low board reset holds both outputs low, sampled on both edges
  a_r1_low_holds_pos: assert property (@(posedge clk) disable iff (scanMode)
    !extRstN |-> (!rstPosN && !rstNegN));
  a_r8_low_holds_neg: assert property (@(negedge clk) disable iff (scanMode)
    !extRstN |-> (!rstPosN && !rstNegN));

  // R4: a request seen at the previous falling edge keeps rstPosN low
  a_r4_sw_pos: assert property (@(negedge clk) disable iff (!extRstN || scanMode)
    $past(swRst) |-> !rstPosN);

  // R5: a request seen at the previous rising edge keeps rstNegN low
  a_r5_sw_neg: assert property (@(posedge clk) disable iff (!extRstN || scanMode)
    $past(swRst) |-> !rstNegN);

  // R2: rstPosN rises only at a falling edge at which the board reset was high
  a_r2_pos_release: assert property (@(negedge clk) disable iff (scanMode || !extRstN)
    $rose(rstPosN) |-> $past(extRstN));

  // R7: in scan mode with the board reset high, both outputs are released
  a_r7_scan_pass: assert property (@(posedge clk) disable iff (!extRstN)
    scanMode |-> (rstPosN && rstNegN));

endmodule

bind edge_reset_gen edge_reset_gen_chk u_chk (.*);

// File: tb/sim_edge_reset_gen.sv
`timescale 1ns/1ps
module sim_edge_reset_gen;

  localparam int STAGES = 2;

  logic clk = 1'b0;
  logic clkRun = 1'b1;
  logic extRstN = 1'b0;
  logic swRst = 1'b0;
  logic scanMode = 1'b0;
  logic rstPosN;
  logic rstNegN;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // 200 MHz clock that the bench can freeze
  always begin
    #2.5;
    if (clkRun) clk = ~clk;
  end

  edge_reset_gen #(.STAGES(STAGES)) u0 (
    .clk      (clk),
    .extRstN  (extRstN),
    .swRst    (swRst),
    .scanMode (scanMode),
    .rstPosN  (rstPosN),
    .rstNegN  (rstNegN)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // R1: reset state and immediate assertion
  task automatic test_reset_state();
    #1;
    chk("R1", "rstPosN at start", rstPosN, 1'b0);
    chk("R1", "rstNegN at start", rstNegN, 1'b0);
  endtask

  // R2, R3: release edge polarity and count
  task automatic test_release();
    @(posedge clk); #0.5 extRstN = 1'b1;
    for (int i = 1; i < STAGES; i++) begin
      @(negedge clk); #1;
      chk("R2", "rstPosN before last fall", rstPosN, 1'b0);
      @(posedge clk); #1;
      chk("R3", "rstNegN before last rise", rstNegN, 1'b0);
    end
    @(negedge clk); #1;
    chk("R2", "rstPosN at last fall", rstPosN, 1'b1);
    chk("R3", "rstNegN still held at fall", rstNegN, 1'b0);
    @(posedge clk); #1;
    chk("R3", "rstNegN at last rise", rstNegN, 1'b1);
  endtask

  // R8: held in reset while the clock runs
  task automatic test_hold_running();
    @(posedge clk); #0.5 extRstN = 1'b0;
    #0.5;
    chk("R8", "rstPosN immediate", rstPosN, 1'b0);
    repeat (4) @(negedge clk);
    #1;
    chk("R8", "rstPosN held", rstPosN, 1'b0);
    chk("R8", "rstNegN held", rstNegN, 1'b0);
    test_release();
  endtask

  // R4, R5, R6: software request timing
  task automatic test_software();
    @(posedge clk); #0.5 swRst = 1'b1;
    #1;
    chk("R4", "rstPosN before fall", rstPosN, 1'b1);
    chk("R5", "rstNegN before rise", rstNegN, 1'b1);
    @(negedge clk); #1;
    chk("R4", "rstPosN at fall", rstPosN, 1'b0);
    chk("R5", "rstNegN not yet", rstNegN, 1'b1);
    @(posedge clk); #1;
    chk("R5", "rstNegN at rise", rstNegN, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    chk("R4", "rstPosN kept", rstPosN, 1'b0);
    chk("R5", "rstNegN kept", rstNegN, 1'b0);
    @(posedge clk); #0.5 swRst = 1'b0;
    @(negedge clk); #1;
    chk("R6", "rstPosN released", rstPosN, 1'b1);
    chk("R6", "rstNegN still held", rstNegN, 1'b0);
    @(posedge clk); #1;
    chk("R6", "rstNegN released", rstNegN, 1'b1);
  endtask

  // R1, R9: assertion and no release with a frozen clock
  task automatic test_stopped_clock();
    @(posedge clk); #1 clkRun = 1'b0;
    #6;
    extRstN = 1'b0;
    #0.2;
    chk("R1", "rstPosN without clock", rstPosN, 1'b0);
    chk("R1", "rstNegN without clock", rstNegN, 1'b0);
    #3 extRstN = 1'b1;
    #20;
    chk("R9", "rstPosN frozen", rstPosN, 1'b0);
    chk("R9", "rstNegN frozen", rstNegN, 1'b0);
    clkRun = 1'b1;
    repeat (STAGES + 1) @(posedge clk);
    #1;
    chk("R2", "rstPosN after restart", rstPosN, 1'b1);
    chk("R3", "rstNegN after restart", rstNegN, 1'b1);
  endtask

  // R7: scan pass-through
  task automatic test_scan();
    @(posedge clk); #0.2 scanMode = 1'b1;
    #0.3 extRstN = 1'b0;
    #0.3;
    chk("R7", "rstPosN follows low", rstPosN, 1'b0);
    chk("R7", "rstNegN follows low", rstNegN, 1'b0);
    extRstN = 1'b1;
    #0.3;
    chk("R7", "rstPosN follows high", rstPosN, 1'b1);
    chk("R7", "rstNegN follows high", rstNegN, 1'b1);
    swRst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R7", "rstPosN ignores swRst", rstPosN, 1'b1);
    chk("R7", "rstNegN ignores swRst", rstNegN, 1'b1);
    swRst = 1'b0;
    repeat (2) @(posedge clk);
    #0.5 scanMode = 1'b0;
    #0.5;
    chk("R7", "rstPosN after scan", rstPosN, 1'b1);
    chk("R7", "rstNegN after scan", rstNegN, 1'b1);
  endtask

  initial begin
    test_reset_state();
    test_release();
    test_hold_running();
    test_software();
    test_stopped_clock();
    test_scan();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule